// File: doc/BRIEF.md
# Memory Access Path Classifier

This block sits between a load/store issue stage and the memory hierarchy. Each incoming request carries a virtual address, a write flag and two access-behaviour flags: a bypass flag for active (memory-mapped) objects and a shared-visibility flag for data that other agents may change. Static configuration inputs give the core topology and say what the highest shared level is. From these the block decides three things:

- whether address translation is skipped,
- whether caches may allocate the line,
- which level of the hierarchy must serve the access.

The decision is registered on a valid/ready handshake, so the output has one cycle of latency.

All of physical memory is visible as a fixed identity-mapped window starting at virtual address zero. The window size is a parameter. Accesses inside the window skip translation but stay cacheable. The bypass flag always sends a request to the aperture level, which sits below every cache. The shared-visibility flag changes routing only when the cores are not kept coherent. In that case the access goes uncached to the highest shared level, which is either a shared cache or DRAM.

The output stage is a two-state machine. `ST_EMPTY` holds no request. `ST_FULL` holds one routed request. Its transitions are:

- LOAD (`ST_EMPTY` to `ST_FULL`): a request is accepted.
- HOLD (`ST_FULL` to `ST_FULL`): the consumer is not ready.
- REFILL (`ST_FULL` to `ST_FULL`): the held request leaves and a new one enters on the same edge.
- DRAIN (`ST_FULL` to `ST_EMPTY`): the held request leaves and nothing new arrives.

Top module: `mem_route_classifier`

## Requirements
- R1: A request with `in_nocache`=1 leaves with `out_level`=3 (aperture) and `out_cache_alloc`=0.
- R2: `out_translate` is 0 when the address is below `PHYS_LIMIT` and 1 otherwise, for every flag combination.
- R3: A request with neither flag set leaves with `out_level`=0 (private cache) and `out_cache_alloc`=1.
- R4: With `cfg_topo`=0 (single core), `in_volatile` has no effect: the routing equals that of a plain request.
- R5: With `cfg_topo`=1 (coherent multicore), `in_volatile` has no effect on routing.
- R6: With `cfg_topo`=2 or 3 (incoherent multicore) and `cfg_shared_dram`=0, a volatile request without `in_nocache` leaves with `out_level`=1 (shared cache) and `out_cache_alloc`=0.
- R7: With an incoherent topology and `cfg_shared_dram`=1, a volatile request without `in_nocache` leaves with `out_level`=2 (DRAM) and `out_cache_alloc`=0.
- R8: When both flags are set, the bypass flag wins: the routing equals R1 in every topology.
- R9: A request accepted at a clock edge is presented on the outputs with `out_valid`=1 right after that edge, with its address and write flag unchanged.
- R10: While `out_valid`=1 and `out_ready`=0, the outputs stay stable and `in_ready`=0. Requests leave in acceptance order, none lost and none duplicated.
- R11: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_topo | input | 2 | 0 single core, 1 coherent multicore, 2/3 incoherent multicore |
| cfg_shared_dram | input | 1 | 1: the highest shared level is DRAM; 0: it is a shared cache |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | ADDR_W | Virtual address |
| in_write | input | 1 | 1 write, 0 read |
| in_nocache | input | 1 | Bypass-all-caches flag |
| in_volatile | input | 1 | Shared-visibility flag |
| out_valid | output | 1 | Routed request valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | ADDR_W | Address, passed through |
| out_write | output | 1 | Write flag, passed through |
| out_level | output | 2 | Target level: 0 private, 1 shared cache, 2 DRAM, 3 aperture |
| out_cache_alloc | output | 1 | Caches may allocate the line |
| out_translate | output | 1 | Address must go through translation |

## Verification
Two things can happen on the same edge: the held routed request is handed downstream, and a new request is accepted and classified (the REFILL transition). The bench provokes this with back-to-back requests while `out_ready` follows a pseudo-random pattern. Every handshake on the output is compared against a queue of expected routings, so an overwrite, a drop or a repeat during a REFILL shows up as an order or content mismatch. Directed cases separately pin down HOLD stability and the first-cycle latency.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
    typedef enum logic [1:0] {
        LVL_PRIVATE  = 2'd0,
        LVL_SHARED   = 2'd1,
        LVL_DRAM     = 2'd2,
        LVL_APERTURE = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        TOPO_SINGLE     = 2'd0,
        TOPO_COHERENT   = 2'd1,
        TOPO_INCOHERENT = 2'd2,
        TOPO_INCOH_ALT  = 2'd3
    } topo_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;
endpackage

// File: rtl/mrc_decide.sv
module mrc_decide
    import mrc_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 40,
    parameter logic [ADDR_W-1:0] PHYS_LIMIT = 40'h00_4000_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              nocache,
    input  logic              vol,
    input  logic [1:0]        topo,
    input  logic              shared_dram,
    output logic [1:0]        level,
    output logic              alloc,
    output logic              translate
);
    logic  in_window;
    logic  incoherent;
    topo_e topo_q;

    always_comb begin
        topo_q     = topo_e'(topo);
        in_window  = (addr < PHYS_LIMIT);
        incoherent = (topo_q == TOPO_INCOHERENT) || (topo_q == TOPO_INCOH_ALT);
    end

    // Identity window decides translation; the flags never change it.
    assign translate = ~in_window;

    always_comb begin
        level = LVL_PRIVATE;
        alloc = 1'b1;
        if (nocache) begin
            level = LVL_APERTURE;
            alloc = 1'b0;
        end else if (vol && incoherent) begin
            level = shared_dram ? LVL_DRAM : LVL_SHARED;
            alloc = 1'b0;
        end
    end
endmodule

// File: rtl/mrc_stage.sv
module mrc_stage
    import mrc_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    stage_e state, state_nx;
    logic   take;

    assign take = in_valid && in_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // Next state: LOAD, HOLD, REFILL, DRAIN
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (in_valid) state_nx = ST_FULL;                // LOAD
            ST_FULL:  if (out_ready && !in_valid) state_nx = ST_EMPTY; // DRAIN
                      else state_nx = ST_FULL;                         // HOLD / REFILL
            default:  state_nx = ST_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = (state == ST_FULL);
        in_ready  = (state == ST_EMPTY) || out_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    out_data <= '0;
        else if (take) out_data <= in_data;
    end

    // R10: a stalled result is neither changed nor dropped
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: input is stalled while the held result waits
    p_stall_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R9: an accepted request is visible after one edge
    p_accept_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/mem_route_classifier.sv
module mem_route_classifier
    import mrc_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 40,
    parameter logic [ADDR_W-1:0] PHYS_LIMIT = 40'h00_4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_topo,
    input  logic              cfg_shared_dram,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic              in_nocache,
    input  logic              in_volatile,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic [1:0]        out_level,
    output logic              out_cache_alloc,
    output logic              out_translate
);
    localparam int unsigned PW = ADDR_W + 5;

    logic [1:0]    d_level;
    logic          d_alloc;
    logic          d_translate;
    logic [PW-1:0] pack_in;
    logic [PW-1:0] pack_out;

    mrc_decide #(.ADDR_W(ADDR_W), .PHYS_LIMIT(PHYS_LIMIT)) u_decide (
        .addr        (in_addr),
        .nocache     (in_nocache),
        .vol         (in_volatile),
        .topo        (cfg_topo),
        .shared_dram (cfg_shared_dram),
        .level       (d_level),
        .alloc       (d_alloc),
        .translate   (d_translate)
    );

    assign pack_in = {in_addr, in_write, d_level, d_alloc, d_translate};

    mrc_stage #(.W(PW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (pack_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (pack_out)
    );

    assign {out_addr, out_write, out_level, out_cache_alloc, out_translate} = pack_out;

    // R1: nothing routed to the aperture may allocate in a cache
    p_aperture_noalloc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_level == LVL_APERTURE) |-> !out_cache_alloc);

    // R2: translation follows the identity window on the routed address
    p_window_translate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_translate == (out_addr >= PHYS_LIMIT)));

    // R3: only private-level routing allocates
    p_alloc_private_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cache_alloc) |-> (out_level == LVL_PRIVATE));

    // R11: empty after reset
    p_reset_empty_r11: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/tb_mem_route_classifier.sv
`timescale 1ns/1ps
module tb_mem_route_classifier;
    localparam int unsigned AW = 40;
    localparam logic [AW-1:0] LIM = 40'h00_4000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_topo = 2'd0;
    logic          cfg_shared_dram = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_addr = '0;
    logic          in_write = 1'b0;
    logic          in_nocache = 1'b0;
    logic          in_volatile = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic          out_write;
    logic [1:0]    out_level;
    logic          out_cache_alloc;
    logic          out_translate;

    always #2.5 clk = ~clk;

    mem_route_classifier #(.ADDR_W(AW), .PHYS_LIMIT(LIM)) dut (.*);

    typedef struct {
        logic [AW-1:0] addr;
        logic          wr;
        logic [1:0]    lvl;
        logic          alloc;
        logic          tr;
        string         tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    rmode = 0;          // 0 always ready, 1 never, 2 pseudo-random
    logic [7:0] lfsr = 8'hA5;

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'b0 : lfsr[0];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model built from the requirements
    function automatic item_t model(input logic [AW-1:0] a, input logic w,
                                    input logic nc, input logic v, input string tag);
        item_t it;
        it.addr = a; it.wr = w; it.tag = tag;
        it.tr = (a >= LIM);
        if (nc) begin
            it.lvl = 2'd3; it.alloc = 1'b0;
        end else if (v && cfg_topo >= 2'd2) begin
            it.lvl = cfg_shared_dram ? 2'd2 : 2'd1; it.alloc = 1'b0;
        end else begin
            it.lvl = 2'd0; it.alloc = 1'b1;
        end
        return it;
    endfunction

    task automatic send(input logic [AW-1:0] a, input logic w, input logic nc,
                        input logic v, input string tag);
        exp_q.push_back(model(a, w, nc, v, tag));
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_write = w; in_nocache = nc; in_volatile = v;
        #0.5;
        while (!in_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        #0.5;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare every output handshake against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected output", 64'(out_addr), 64'h0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(out_addr == e.addr && out_write == e.wr && out_level == e.lvl &&
                    out_cache_alloc == e.alloc && out_translate == e.tr, e.tag,
                    "route {addr,wr,lvl,alloc,tr}",
                    {19'(out_addr), out_write, out_level, out_cache_alloc, out_translate},
                    {19'(e.addr), e.wr, e.lvl, e.alloc, e.tr});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "timeout", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [AW-1:0] held;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R11", "{out_valid,in_ready} after reset",
            {62'd0, out_valid, in_ready}, 64'd1);

        // single core
        cfg_topo = 2'd0; cfg_shared_dram = 1'b0;
        send(40'h100, 1'b0, 1'b0, 1'b0, "R3");
        chk(out_valid == 1'b1 && out_addr == 40'h100, "R9", "valid one edge after accept",
            64'(out_addr), 64'h100);
        send(40'h80_0000_1000, 1'b1, 1'b0, 1'b0, "R2");
        send(40'h2000, 1'b1, 1'b0, 1'b1, "R4");
        send(40'h80_0000_2000, 1'b0, 1'b0, 1'b1, "R4");
        send(40'h3000, 1'b0, 1'b1, 1'b0, "R1");
        send(40'h90_0000_0000, 1'b1, 1'b1, 1'b0, "R1");
        drain();

        // coherent multicore
        cfg_topo = 2'd1;
        send(40'h80_0000_4000, 1'b0, 1'b0, 1'b1, "R5");
        send(40'h4000, 1'b1, 1'b0, 1'b1, "R5");
        send(40'h5000, 1'b0, 1'b1, 1'b1, "R8");
        drain();

        // incoherent, shared cache is top shared level
        cfg_topo = 2'd2; cfg_shared_dram = 1'b0;
        send(40'h6000, 1'b0, 1'b0, 1'b1, "R6");
        send(40'h80_0000_6000, 1'b1, 1'b0, 1'b1, "R6");
        send(40'h7000, 1'b0, 1'b1, 1'b1, "R8");
        drain();

        // incoherent, DRAM is top shared level
        cfg_topo = 2'd3; cfg_shared_dram = 1'b1;
        send(40'h8000, 1'b1, 1'b0, 1'b1, "R7");
        send(40'h80_0000_8000, 1'b0, 1'b1, 1'b1, "R8");
        send(LIM - 40'd1, 1'b0, 1'b0, 1'b0, "R2");
        send(LIM, 1'b0, 1'b0, 1'b1, "R2");
        drain();

        // back-pressure: hold one result, stall the next
        rmode = 1;
        repeat (2) @(negedge clk);
        send(40'hA000, 1'b1, 1'b0, 1'b0, "R10");
        held = out_addr;
        @(negedge clk);
        in_valid = 1'b1; in_addr = 40'hB000; in_write = 1'b0; in_nocache = 1'b0; in_volatile = 1'b0;
        #1;
        chk(in_ready == 1'b0 && out_valid == 1'b1, "R10", "{in_ready,out_valid} while stalled",
            {62'd0, in_ready, out_valid}, 64'd1);
        repeat (3) @(negedge clk);
        #1;
        chk(out_addr == held && out_addr == 40'hA000, "R10", "held address stable",
            64'(out_addr), 64'hA000);
        in_valid = 1'b0;
        rmode = 0;
        drain();

        // random ready with back-to-back traffic (REFILL)
        rmode = 2;
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a;
            a = (i % 3 == 0) ? 40'h80_0000_0000 + 40'(i * 64) : 40'(i * 4096);
            send(a, 1'(i), 1'(i % 5 == 0), 1'(i % 2), "R10");
        end
        rmode = 0;
        drain();
        chk(exp_q.size() == 0, "R10", "scoreboard empty", 64'(exp_q.size()), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule